// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block holds the software-visible state of 32 general-purpose pins. The pins are grouped into four 8-bit ports. For each port the block keeps a use-select byte, an output-enable byte and an output-value byte. It drives these bytes straight onto the pad-facing outputs. It also passes the pad levels through a synchronizer so that software can read them. The multiplexer that picks between GPIO and alternate use, the pad cells and all interrupt logic sit outside this block.

Each writable register can also be reached at a second, masked alias address. In a write to that alias, the upper byte of the write data chooses which pins change and the lower byte gives their new levels. Two pieces of software that each own different pins of the same port can therefore update those pins with one bus write each, without a read-modify-write sequence that could lose the other's update. The bus is word addressed. A request lasts one cycle. Read data is registered and appears one cycle after the request.

Top module: `gpio_mw_bank`

## Requirements
- R1: While reset is held and after it is released, the use-select, output-enable and output-value registers of every port read as 0, and pad_oe, pad_out and gpio_mode are all 0. Every pin therefore starts as an input.
- R2: Byte offsets are word address × 4. A plain write at byte offset 0x00 (use-select), 0x10 (output enable) or 0x20 (output value), plus port × 4, replaces all 8 bits of that port's register with bus_wdata[7:0]. No other register changes. When there is no write, no register changes.
- R3: A write at MASK_OFS plus the same plain offset updates pin n of the register to bus_wdata[n] only where bus_wdata[8+n] is 1. Every pin whose mask bit is 0 keeps its value. A mask of 0x00 changes nothing and a mask of 0xFF acts as a full write.
- R4: A read of a plain register address returns the stored byte in bus_rdata[7:0], with bits 31:8 at 0. The data appears in the cycle after the request.
- R5: A read of a masked alias of use-select, output enable or output value returns the same byte as the plain address.
- R6: A read at byte offset 0x30 + port × 4 returns that port's pad levels after a two-stage synchronizer. A pad level present at clock edge k is returned by a read requested at edge k+2 or later.
- R7: Writes to the input register, at its plain address or at MASK_OFS + 0x30 + port × 4, change no register and no output.
- R8: Addresses outside the two 64-byte windows (plain and masked), including byte offsets 0x40–0x7F and the masked input slots, read as 0 and ignore writes.
- R9: Pin p = port × 8 + bit. pad_out[p], pad_oe[p] and gpio_mode[p] equal bit `bit` of that port's output-value, output-enable and use-select register.
- R10: bus_rdata holds its value in every cycle that follows a cycle with no read request.
- R11: A single bus write changes at most one register kind of one port, so pad_out and pad_oe never change in the same cycle. Software that writes the output value first and then sets the output enable gets a pad that starts driving the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus request valid for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | WADDR_W | Word address (byte offset / 4) |
| bus_wdata | input | 16 | Bits 15:8 = pin mask (masked alias only), bits 7:0 = value |
| bus_rdata | output | 32 | Registered read data, zero-extended |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output value to pads |
| pad_oe | output | 32 | Output enable to pads |
| gpio_mode | output | 32 | Use-select per pin (1 = GPIO use) |

## Verification
The bench targets the masked-alias merge with sparse, empty and full masks. A design that treats the mask as inverted, or writes the whole byte, would corrupt neighbouring pins. Writes aimed at the input register and at the interrupt-sized gap between the windows are checked against all outputs; a loose decoder would alias them onto live registers. Pad input changes are timed against reads to pin the synchronizer depth to exactly two stages. A write of the output value followed by a write of the output enable confirms that the two never move in the same cycle.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
    localparam int PORT_CNT = 4;
    localparam int PORT_W   = 8;
    localparam int PIN_CNT  = PORT_CNT * PORT_W;
    localparam int PSEL_W   = $clog2(PORT_CNT);
    localparam int DATA_W   = 32;
    localparam int WDATA_W  = 2 * PORT_W;

    typedef enum logic [1:0] {
        KIND_CFG = 2'd0,
        KIND_OE  = 2'd1,
        KIND_OUT = 2'd2,
        KIND_IN  = 2'd3
    } reg_kind_e;

    typedef struct packed {
        logic              rd_hit;
        logic              wr_hit;
        logic              masked;
        reg_kind_e         kind;
        logic [PSEL_W-1:0] port;
    } bus_dec_t;

    typedef struct packed {
        logic [PORT_W-1:0] cfg;
        logic [PORT_W-1:0] oe;
        logic [PORT_W-1:0] dout;
    } port_regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_state_t;

    // Plain write: whole byte. Masked write: only bits whose mask bit is set.
    function automatic logic [PORT_W-1:0] merge_bits(
        input logic [PORT_W-1:0]  old_v,
        input logic               masked,
        input logic [WDATA_W-1:0] wd
    );
        logic [PORT_W-1:0] m;
        m = wd[WDATA_W-1:PORT_W];
        if (masked) return (old_v & ~m) | (wd[PORT_W-1:0] & m);
        return wd[PORT_W-1:0];
    endfunction
endpackage

// File: rtl/gpio_mw_decode.sv
module gpio_mw_decode
    import gpio_mw_pkg::*;
#(
    parameter int WADDR_W   = 10,
    parameter int MASK_WORD = 'h20
) (
    input  logic [WADDR_W-1:0] addr,
    output bus_dec_t           dec
);
    // Each window spans 16 words: kind in [3:2], port in [1:0].
    localparam int WIN_LSB = 2 + PSEL_W;
    localparam int BLK_W   = WADDR_W - WIN_LSB;
    localparam logic [BLK_W-1:0] MASK_BLK = BLK_W'(MASK_WORD >> WIN_LSB);

    logic [BLK_W-1:0] blk;
    logic             in_plain;
    logic             in_mask;
    reg_kind_e        kind;

    always_comb begin
        blk      = addr[WADDR_W-1:WIN_LSB];
        in_plain = (blk == '0);
        in_mask  = (blk == MASK_BLK);
        kind     = reg_kind_e'(addr[PSEL_W+1:PSEL_W]);

        dec.kind   = kind;
        dec.port   = addr[PSEL_W-1:0];
        dec.masked = in_mask;
        dec.rd_hit = in_plain | (in_mask & (kind != KIND_IN));
        dec.wr_hit = (in_plain | in_mask) & (kind != KIND_IN);
    end
endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
    import gpio_mw_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_masked,
    input  reg_kind_e          wr_kind,
    input  logic [WDATA_W-1:0] wr_data,
    output logic [PORT_W-1:0]  cfg,
    output logic [PORT_W-1:0]  oe,
    output logic [PORT_W-1:0]  dout
);
    port_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (wr_kind)
                KIND_CFG: r_d.cfg  = merge_bits(r_q.cfg,  wr_masked, wr_data);
                KIND_OE:  r_d.oe   = merge_bits(r_q.oe,   wr_masked, wr_data);
                KIND_OUT: r_d.dout = merge_bits(r_q.dout, wr_masked, wr_data);
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg  = r_q.cfg;
    assign oe   = r_q.oe;
    assign dout = r_q.dout;

    // R2: a plain write replaces the whole byte
    p_plain_replace_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_masked && wr_kind == KIND_OE) |=> (oe == $past(wr_data[PORT_W-1:0])));

    // R2: without a write the port state is frozen
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(r_q));

    // R3: unmasked pins keep their value
    p_keep_unmasked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_masked && wr_kind == KIND_OUT)
        |=> (((dout ^ $past(dout)) & ~$past(wr_data[WDATA_W-1:PORT_W])) == '0));
endmodule

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] s_d, s_q;

    always_comb begin
        s_d[0] = din;
        for (int i = 1; i < STAGES; i++) s_d[i] = s_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout = s_q[STAGES-1];
endmodule

// File: rtl/gpio_mw_bank.sv
module gpio_mw_bank
    import gpio_mw_pkg::*;
#(
    parameter int WADDR_W     = 10,
    parameter int MASK_OFS    = 'h80,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_req,
    input  logic               bus_wr,
    input  logic [WADDR_W-1:0] bus_addr,
    input  logic [15:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [31:0]        pad_in,
    output logic [31:0]        pad_out,
    output logic [31:0]        pad_oe,
    output logic [31:0]        gpio_mode
);
    localparam int MASK_WORD = MASK_OFS / 4;

    bus_dec_t                         dec;
    logic [PORT_CNT-1:0][PORT_W-1:0]  cfg_a, oe_a, out_a, in_a;
    logic [PIN_CNT-1:0]               in_sync;
    logic [PORT_W-1:0]                sel_v;
    rd_state_t                        st_d, st_q;

    gpio_mw_decode #(
        .WADDR_W  (WADDR_W),
        .MASK_WORD(MASK_WORD)
    ) u_dec (
        .addr(bus_addr),
        .dec (dec)
    );

    gpio_mw_sync #(
        .WIDTH (PIN_CNT),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (in_sync)
    );

    assign in_a = in_sync;

    for (genvar p = 0; p < PORT_CNT; p++) begin : g_port
        logic we;
        assign we = bus_req & bus_wr & dec.wr_hit & (dec.port == PSEL_W'(p));
        gpio_mw_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (we),
            .wr_masked(dec.masked),
            .wr_kind  (dec.kind),
            .wr_data  (bus_wdata),
            .cfg      (cfg_a[p]),
            .oe       (oe_a[p]),
            .dout     (out_a[p])
        );
    end

    assign pad_out   = out_a;
    assign pad_oe    = oe_a;
    assign gpio_mode = cfg_a;

    always_comb begin
        unique case (dec.kind)
            KIND_CFG: sel_v = cfg_a[dec.port];
            KIND_OE:  sel_v = oe_a[dec.port];
            KIND_OUT: sel_v = out_a[dec.port];
            default:  sel_v = in_a[dec.port];
        endcase
        st_d = st_q;
        if (bus_req && !bus_wr)
            st_d.rdata = dec.rd_hit ? DATA_W'(sel_v) : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R8: unmapped reads return zero
    p_unmapped_rd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && !dec.rd_hit) |=> (bus_rdata == '0));

    // R7: writes that hit no writable register leave all outputs alone
    p_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_wr && !dec.wr_hit)
        |=> ($stable(pad_out) && $stable(pad_oe) && $stable(gpio_mode)));

    // R10: read data holds without a read
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && !bus_wr) |=> $stable(bus_rdata));

    // R11: output value and output enable never move together
    p_one_kind_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !((pad_out != $past(pad_out)) && (pad_oe != $past(pad_oe))));
endmodule

// File: tb/gpio_mw_bank_test.sv
`timescale 1ns/1ps
module gpio_mw_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_wr = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = 32'h0;
    logic [31:0] pad_out, pad_oe, gpio_mode;

    int    total = 0;
    int    bad = 0;
    bit    done = 1'b0;
    string tag = "R1";

    always #2.5 clk = ~clk;

    gpio_mw_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .gpio_mode(gpio_mode)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0]  m_cfg [4];
    logic [7:0]  m_oe  [4];
    logic [7:0]  m_out [4];
    logic [31:0] m_rd, m_s1, m_s2;

    function automatic logic [31:0] ref_read(input int a);
        int w, k, p;
        if (a < 16) w = a;
        else if (a >= 32 && a < 48) w = a - 32;
        else return 0;
        k = w / 4; p = w % 4;
        if (k == 3 && a >= 32) return 0;
        case (k)
            0: return {24'h0, m_cfg[p]};
            1: return {24'h0, m_oe[p]};
            2: return {24'h0, m_out[p]};
            default: return {24'h0, m_s2[p*8 +: 8]};
        endcase
    endfunction

    function automatic logic [7:0] upd(input logic [7:0] o, input bit msk, input logic [15:0] d);
        if (!msk) return d[7:0];
        return (o & ~d[15:8]) | (d[7:0] & d[15:8]);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin m_cfg[i] = 0; m_oe[i] = 0; m_out[i] = 0; end
            m_rd = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (bus_req && !bus_wr) m_rd = ref_read(int'(bus_addr));
            if (bus_req && bus_wr) begin
                int a, w, k, p;
                bit msk, ok;
                a = int'(bus_addr); ok = 1; msk = 0; w = 0;
                if (a < 16) w = a;
                else if (a >= 32 && a < 48) begin w = a - 32; msk = 1; end
                else ok = 0;
                k = w / 4; p = w % 4;
                if (ok) begin
                    if (k == 0) m_cfg[p] = upd(m_cfg[p], msk, bus_wdata);
                    else if (k == 1) m_oe[p] = upd(m_oe[p], msk, bus_wdata);
                    else if (k == 2) m_out[p] = upd(m_out[p], msk, bus_wdata);
                end
            end
            m_s2 = m_s1;
            m_s1 = pad_in;
        end
    end

    task automatic check(input string t, input logic [31:0] got, input logic [31:0] exp, input string what);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h at %0t", t, what, got, exp, $time);
        end
    endtask

    // per-clock comparison against the reference (R9 mapping, R4/R10 read data)
    always @(negedge clk) begin
        logic [31:0] eo, ee, ec;
        if (!done) begin
            for (int p = 0; p < 4; p++) begin
                ec[p*8 +: 8] = m_cfg[p]; ee[p*8 +: 8] = m_oe[p]; eo[p*8 +: 8] = m_out[p];
            end
            check(tag, pad_out,   eo, "pad_out (R9)");
            check(tag, pad_oe,    ee, "pad_oe (R9)");
            check(tag, gpio_mode, ec, "gpio_mode (R9)");
            check(tag, bus_rdata, m_rd, "bus_rdata (R4)");
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk); bus_req = 1; bus_wr = 1; bus_addr = 10'(a); bus_wdata = d;
    endtask

    task automatic rd(input int a);
        @(negedge clk); bus_req = 1; bus_wr = 0; bus_addr = 10'(a);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bus_req = 0; bus_wr = 0;
        end
    endtask

    task automatic rd_chk(input int a, input logic [31:0] exp, input string t);
        rd(a);
        @(negedge clk); bus_req = 0;
        check(t, bus_rdata, exp, "directed read");
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        tag = "R1";
        pad_in = 32'hDEAD_BEEF;
        repeat (4) @(negedge clk);
        check("R1", pad_oe, 32'h0, "pad_oe in reset");
        rst_n = 1;
        idle(3);
        check("R1", pad_out, 32'h0, "pad_out after reset");
        check("R1", gpio_mode, 32'h0, "gpio_mode after reset");
        rd_chk(8 + 2, 32'h0, "R1");

        tag = "R2";
        for (int p = 0; p < 4; p++) begin
            wr(0 + p, 16'hFF00 | 16'(8'h11 * (p + 1)));
            wr(4 + p, 16'(8'h3C ^ p));
            wr(8 + p, 16'(8'hA0 + p));
        end
        idle(1);
        wr(8 + 1, 16'h005A);
        idle(2);

        tag = "R4";
        for (int a = 0; a < 12; a++) rd(a);
        idle(1);
        rd_chk(8 + 1, 32'h0000_005A, "R4");

        tag = "R3";
        wr(32 + 8 + 1, 16'h0F03);
        idle(1);
        rd_chk(8 + 1, 32'h0000_0053, "R3");
        wr(32 + 8 + 1, 16'h00FF);
        idle(1);
        rd_chk(8 + 1, 32'h0000_0053, "R3");
        wr(32 + 8 + 1, 16'hFFC6);
        idle(1);
        rd_chk(8 + 1, 32'h0000_00C6, "R3");
        wr(32 + 0 + 3, 16'h8180);
        wr(32 + 4 + 0, 16'h2424);
        wr(32 + 4 + 2, 16'h0100);
        idle(2);

        tag = "R5";
        for (int a = 32; a < 44; a++) rd(a);
        idle(1);
        rd_chk(32 + 8 + 1, 32'h0000_00C6, "R5");

        tag = "R6";
        pad_in = 32'h1234_5678;
        idle(3);
        rd_chk(12 + 0, 32'h0000_0078, "R6");
        rd_chk(12 + 3, 32'h0000_0012, "R6");
        @(negedge clk); pad_in = 32'hA5A5_0F0F; bus_req = 1; bus_wr = 0; bus_addr = 10'd13;
        rd(13); rd(13); rd(13);
        idle(2);

        tag = "R7";
        for (int p = 0; p < 4; p++) begin
            wr(12 + p, 16'hFFFF);
            wr(32 + 12 + p, 16'hFFFF);
        end
        idle(2);
        rd_chk(32 + 12 + 1, 32'h0, "R7");

        tag = "R8";
        for (int a = 16; a < 32; a++) wr(a, 16'hFFFF);
        wr(10'h40, 16'hFFFF);
        wr(10'h200, 16'hFFFF);
        wr(10'h3FF, 16'hFFFF);
        idle(1);
        rd_chk(10'h14, 32'h0, "R8");
        rd_chk(10'h200, 32'h0, "R8");
        rd_chk(10'h30, 32'h0, "R8");

        tag = "R9";
        wr(8 + 0, 16'h0001);
        wr(8 + 3, 16'h0080);
        wr(4 + 3, 16'h0080);
        idle(2);
        check("R9", pad_out & 32'h8000_0001, 32'h8000_0001, "pin 0 and pin 31 drive");

        tag = "R10";
        rd(8 + 3);
        wr(8 + 3, 16'h0000);
        idle(4);
        check("R10", bus_rdata, 32'h0000_0080, "held read data");

        tag = "R11";
        wr(4 + 2, 16'h0000);
        wr(8 + 2, 16'h00F0);
        wr(4 + 2, 16'h00FF);
        idle(2);
        check("R11", pad_oe[23:16] == 8'hFF && pad_out[23:16] == 8'hF0 ? 32'd1 : 32'd0, 32'd1,
              "output-first then enable");

        tag = "R2";
        idle(2);
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule